// File: doc/BRIEF.md
# Configurable Output Logic Macrocell

This block is one output cell of a small sum-of-products programmable logic fabric. It ORs a parameterised group of product-term results into a single sum. A two-bit configuration then decides two things: whether that sum passes straight to the pin or through a D register, and whether the pin level is inverted. A dedicated product term drives the output enable, so the pin can be held as an output, held as an input, or turned around by logic.

Two terms are shared by every cell in the fabric. One clears the register at once, without waiting for a clock. The other sets the register, but only at the next rising clock edge. The cell returns one feedback signal to the array. In registered mode the feedback is the register's own value. In combinational mode it is whatever the pin carries: the cell's driven level when the driver is enabled, and the external level when it is not.

The configuration is loaded while the cell is held in its synchronous reset. It is then fixed until the next reset.

Top module: `olmc_cell`

## Requirements
- R1: The sum is the OR of all NUM_TERMS product-term inputs. NUM_TERMS is even and lies between 8 and 16. Any single term at 1, including the lowest and the highest index, makes the sum 1.
- R2: Configuration bit 1 selects the path: 0 is registered, 1 is combinational. Configuration bit 0 selects the polarity: 1 drives the selected value unchanged, 0 drives it inverted. This gives code 00 = registered active-low, 01 = registered active-high, 10 = combinational active-low, 11 = combinational active-high.
- R3: In registered mode, the register takes the sum at a rising clock edge. The pin output reflects the new value after that edge.
- R4: In combinational mode, the pin output follows the sum in the same cycle, with no clock edge needed.
- R5: `pin_oe_o` always equals the output-enable product term.
- R6: In registered mode, `fb_o` equals the register value. It does not depend on `pin_in_i`, on the enable term, or on the polarity.
- R7: In combinational mode, `fb_o` equals `pin_out_o` while the enable term is 1. It equals `pin_in_i` while the enable term is 0.
- R8: While the shared reset term is 1, the register is 0. It clears without a clock edge and overrides both the preset term and the sum.
- R9: The shared preset term sets the register to 1 at the next rising edge, ahead of the sum.
- R10: While `rst_n` is low at a rising edge, the register is cleared and the configuration inputs are loaded. A registered active-low cell therefore drives 1 after reset.
- R11: A change of the configuration inputs while `rst_n` is high has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the configuration |
| cfg_i | input | 2 | Configuration: bit 1 selects combinational mode, bit 0 selects active-high polarity |
| pt_i | input | NUM_TERMS | Product-term results that are ORed into the sum |
| oe_pt_i | input | 1 | Output-enable product term |
| ar_pt_i | input | 1 | Shared asynchronous register-clear term |
| sp_pt_i | input | 1 | Shared synchronous register-set term |
| pin_in_i | input | 1 | Level seen on the pin from outside |
| pin_out_o | output | 1 | Level driven to the pin |
| pin_oe_o | output | 1 | Pin driver enable |
| fb_o | output | 1 | Feedback signal to the array |

## Verification
The bench builds the cell with NUM_TERMS set to 16, the widest legal sum. This places the highest-index term, the last OR pair, within reach of a single-term check. Each of the four configuration codes is loaded through a reset and then driven with the following stimulus:
- single-term and all-zero sums;
- feedback with the driver both enabled and disabled, and with the external pin level toggled;
- a preset followed by a clear that arrives between clock edges while preset is still held;
- a configuration change without reset.

// File: rtl/olmc_pkg.sv
// Package olmc_pkg: types shared by the macrocell modules.
// Assumes: the configuration is two bits, with the mode in the upper bit.
package olmc_pkg;

    // Decoded configuration of one cell
    typedef struct packed {
        logic comb_mode;   // 1: combinational path, 0: registered path
        logic act_high;    // 1: drive the value unchanged, 0: drive it inverted
    } olmc_cfg_t;

    // Turns the raw configuration code into the decoded form
    function automatic olmc_cfg_t decode_cfg(input logic [1:0] code);
        olmc_cfg_t c;
        c.comb_mode = code[1];
        c.act_high  = code[0];
        return c;
    endfunction

endpackage

// File: rtl/olmc_sum.sv
// Module olmc_sum: the OR sum of the product terms that feed one cell.
// Assumes: NUM_TERMS is even, from 8 to 16. The terms are ORed in pairs
// first, and the pair results are then reduced.
module olmc_sum #(
    parameter int NUM_TERMS = 8
) (
    input  logic [NUM_TERMS-1:0] pt_i,
    output logic                 sum_o
);
    localparam int NUM_PAIRS = NUM_TERMS / 2;

    logic [NUM_PAIRS-1:0] pair_or;

    // One OR gate for each pair of adjacent terms
    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        assign pair_or[k] = pt_i[2*k] | pt_i[2*k+1];
    end

    // Reduce the pair results to the final sum
    always_comb begin
        sum_o = |pair_or;
    end

endmodule

// File: rtl/olmc_state_reg.sv
// Module olmc_state_reg: the storage flop of the cell and the configuration
// latch.
// Assumes: ar_i clears the flop asynchronously and has the highest priority;
// rst_n is a synchronous reset; sp_i sets the flop at a clock edge. The
// configuration is captured only while rst_n is low.
module olmc_state_reg
    import olmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_i,
    input  logic       ar_i,
    input  logic       sp_i,
    input  logic       sum_i,
    output logic       q_o,
    output olmc_cfg_t  cfg_o
);
    // Storage flop: asynchronous clear, then reset, then preset, then the sum
    always_ff @(posedge clk or posedge ar_i) begin
        if (ar_i) begin
            q_o <= 1'b0;
        end else if (!rst_n) begin
            q_o <= 1'b0;
        end else if (sp_i) begin
            q_o <= 1'b1;
        end else begin
            q_o <= sum_i;
        end
    end

    // Configuration capture, enabled only during reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o <= decode_cfg(cfg_i);
        end
    end

    AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ar_i |-> (q_o == 1'b0)); // R8

    AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_i && !ar_i) |=> (q_o || ar_i)); // R9

    AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sp_i && !ar_i) |=> (ar_i || (q_o == $past(sum_i)))); // R3

endmodule

// File: rtl/olmc_out_path.sv
// Module olmc_out_path: chooses between the registered and combinational
// value, applies the polarity, drives the pin bundle and picks the feedback.
// Assumes: in registered mode the feedback is the non-inverted flop value;
// in combinational mode the feedback is the pin level.
module olmc_out_path
    import olmc_pkg::*;
(
    input  olmc_cfg_t cfg_i,
    input  logic      sum_i,
    input  logic      q_i,
    input  logic      oe_i,
    input  logic      pin_in_i,
    output logic      pin_out_o,
    output logic      pin_oe_o,
    output logic      fb_o
);
    logic core_val;

    // Select between the register and the bypass path
    always_comb begin
        core_val = cfg_i.comb_mode ? sum_i : q_i;
    end

    // Apply the polarity on the way to the pin
    always_comb begin
        pin_out_o = cfg_i.act_high ? core_val : ~core_val;
        pin_oe_o  = oe_i;
    end

    // Feedback: the flop in registered mode, the pin level in combinational mode
    always_comb begin
        if (!cfg_i.comb_mode) begin
            fb_o = q_i;
        end else if (oe_i) begin
            fb_o = pin_out_o;
        end else begin
            fb_o = pin_in_i;
        end
    end

endmodule

// File: rtl/olmc_cell.sv
// Module olmc_cell: top of one configurable output macrocell.
// Assumes: cfg_i is static and is loaded while rst_n is low. ar_pt_i and
// sp_pt_i are shared fabric terms that are wired to every cell.
module olmc_cell
    import olmc_pkg::*;
#(
    parameter int NUM_TERMS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cfg_i,
    input  logic [NUM_TERMS-1:0] pt_i,
    input  logic                 oe_pt_i,
    input  logic                 ar_pt_i,
    input  logic                 sp_pt_i,
    input  logic                 pin_in_i,
    output logic                 pin_out_o,
    output logic                 pin_oe_o,
    output logic                 fb_o
);
    logic      sum;
    logic      q;
    olmc_cfg_t cfg_q;

    // OR sum of the product terms
    olmc_sum #(.NUM_TERMS(NUM_TERMS)) u_sum (
        .pt_i  (pt_i),
        .sum_o (sum)
    );

    // Storage flop and configuration latch
    olmc_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg_i (cfg_i),
        .ar_i  (ar_pt_i),
        .sp_i  (sp_pt_i),
        .sum_i (sum),
        .q_o   (q),
        .cfg_o (cfg_q)
    );

    // Path selection, polarity and feedback
    olmc_out_path u_out (
        .cfg_i     (cfg_q),
        .sum_i     (sum),
        .q_i       (q),
        .oe_i      (oe_pt_i),
        .pin_in_i  (pin_in_i),
        .pin_out_o (pin_out_o),
        .pin_oe_o  (pin_oe_o),
        .fb_o      (fb_o)
    );

    AST_REG_FB_MATCHES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.comb_mode |-> (pin_out_o == (cfg_q.act_high ? fb_o : ~fb_o))); // R6

    AST_COMB_FB_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.comb_mode && oe_pt_i) |-> (fb_o == pin_out_o)); // R7

    AST_COMB_FB_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.comb_mode && !oe_pt_i) |-> (fb_o == pin_in_i)); // R7

    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_q)); // R11

endmodule

// File: tb/olmc_cell_tb.sv
// Bench for olmc_cell. A driver computes the expected pin bundle from a
// behavioural model and pushes it into a queue; a monitor pops each entry
// and compares it with the outputs, away from the clock edge.
module olmc_cell_tb;
    localparam int NT = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    cfg;
    logic [NT-1:0] pt;
    logic          oe, ar, sp, pin_in;
    logic          pin_out, pin_oe, fb;

    always #10 clk = ~clk;   // 50 MHz

    olmc_cell #(.NUM_TERMS(NT)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_i     (cfg),
        .pt_i      (pt),
        .oe_pt_i   (oe),
        .ar_pt_i   (ar),
        .sp_pt_i   (sp),
        .pin_in_i  (pin_in),
        .pin_out_o (pin_out),
        .pin_oe_o  (pin_oe),
        .fb_o      (fb)
    );

    typedef struct {
        logic [2:0] val;   // {pin_out, pin_oe, fb}
        string      tag;
    } exp_t;

    exp_t sb[$];
    event sample_ev;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    // Behavioural model state
    logic [1:0] m_cfg;
    logic       m_q;

    function automatic exp_t predict(input string tag);
        exp_t e;
        logic s, core, po, f;
        s    = |pt;
        core = m_cfg[1] ? s : m_q;
        po   = m_cfg[0] ? core : ~core;
        f    = m_cfg[1] ? (oe ? po : pin_in) : m_q;
        e.val = {po, oe, f};
        e.tag = tag;
        return e;
    endfunction

    // Monitor: compare every queued expectation with the outputs
    initial begin
        forever begin
            @(sample_ev);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if ({pin_out, pin_oe, fb} !== e.val) begin
                    fails++;
                    $display("FAIL %s: actual {out,oe,fb}=%b expected %b",
                             e.tag, {pin_out, pin_oe, fb}, e.val);
                end
            end
        end
    end

    // Called just after a falling edge: update the model at the rising edge,
    // then check 5 ns later
    task automatic clk_step(input string tag);
        @(posedge clk);
        if (!rst_n) m_cfg = cfg;
        if (ar)          m_q = 1'b0;
        else if (!rst_n) m_q = 1'b0;
        else if (sp)     m_q = 1'b1;
        else             m_q = |pt;
        #5;
        sb.push_back(predict(tag));
        -> sample_ev;
        @(negedge clk);
    endtask

    // Check between edges, with no clock edge in between
    task automatic peek(input string tag);
        #3;
        if (ar) m_q = 1'b0;
        sb.push_back(predict(tag));
        -> sample_ev;
        #1;
    endtask

    task automatic load_cfg(input logic [1:0] c);
        rst_n = 1'b0; cfg = c; ar = 1'b0; sp = 1'b0; pt = '0;
        clk_step("R10 reset clears register and loads cfg");
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; cfg = 2'b00; pt = '0; oe = 1'b0; ar = 1'b0;
        sp = 1'b0; pin_in = 1'b0; m_q = 1'b0; m_cfg = 2'b00;
        @(negedge clk);
        clk_step("R10 reset: registered active-low pin reads 1");
        oe = 1'b1;
        peek("R5 enable term reaches pin_oe");

        for (int c = 0; c < 4; c++) begin
            load_cfg(c[1:0]);
            oe = 1'b1;
            pt = '0; pt[0] = 1'b1;
            peek("R4 same-cycle path (R2 polarity)");
            clk_step("R3 capture of lowest term (R1)");
            pt = '0; pt[NT-1] = 1'b1;
            clk_step("R1 highest term sets sum");
            pt = '0;
            clk_step("R2 polarity with sum 0");
            pin_in = 1'b1; oe = 1'b0;
            peek("R6 R7 feedback, driver off, pin 1");
            pin_in = 1'b0;
            peek("R6 R7 feedback, driver off, pin 0");
            oe = 1'b1; pin_in = 1'b1;
            peek("R6 R7 feedback, driver on");
            sp = 1'b1;
            peek("R9 preset waits for the edge");
            clk_step("R9 preset sets register");
            ar = 1'b1;
            peek("R8 clear acts without a clock");
            clk_step("R8 clear beats preset at the edge");
            ar = 1'b0; sp = 1'b0; pt = '1;
            cfg = ~c[1:0];
            clk_step("R11 cfg change ignored, sum all ones");
            pt = '0;
            clk_step("R11 cfg change ignored, sum zero");
            cfg = c[1:0];
        end

        done = 1'b1;
        #1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule